// File: doc/BRIEF.md
# Infrared Pulse/Space Capture Receiver

This block watches a demodulated infrared line and turns it into a stream of symbol words. A symbol is the time the line spends at its pulse level, followed by the time it spends back at the idle level. Both times are counted in units derived from the system clock. A programmable prescaler makes a 1 µs tick, and a fixed divider turns that into the duration unit, 10 µs by default. Each finished symbol is packed into one 32-bit word and stored in a receive FIFO. A symbol whose total length reaches a programmable limit closes the frame and raises a timeout.

Software reaches the block through a simple word-addressed register port. One register switches the block on. A configuration register holds the prescaler, the frame limit, the pulse polarity and the interrupt level. A busy flag shows when the block is not yet ready for configuration, and a start strobe begins capture. The port also gives the FIFO fill count and a data register that pops one symbol per read. Interrupt mask, status and clear registers complete the set. Three interrupt causes feed one `irq` line: receive level, frame timeout and overflow. The FIFO is never flushed by an overflow. Software drains it and then clears the status.

Top module: `ir_rx_top`

## Requirements
- R1: After reset the block reports busy = 1, count = 0 and status = 0. Configuration reads 0x3E800080, the mask register reads 7 and `irq` is low.
- R2: A control write (address 0) turns the block on through bit 0. When NEED_EXTRA_EN is 1, bit 8 must also be set. Busy (address 2) reads 1 while the block is off and for SETTLE_CYCLES cycles after it turns on, and reads 0 after that.
- R3: A configuration write (address 1) is ignored while busy. A start write (address 3) is ignored while busy or while the raw-mode bit 7 of the configuration is 0.
- R4: Configuration bits 6:0 hold the prescaler, equal to clocks per µs minus one. Durations count whole units of UNIT_TICKS µs, and the count restarts at every filtered level change.
- R5: Each FIFO word holds the pulse duration in bits 15:0 and the space duration in bits 31:16. A symbol starts on a transition into the pulse level. Configuration bits 15:14 select the pulse level: the value 1 means the pulse is high, and any other value means the pulse is low with the line idle high.
- R6: When pulse plus space reaches the nonzero limit in configuration bits 31:16, the symbol is stored, the timeout raw flag is set and the receiver waits for a fresh transition into the pulse level. A limit of 0 disables the timeout.
- R7: Duration counts saturate at 0xFFFF.
- R8: A level change that lasts fewer than FILTER_LEN clocks after the two-flop synchronizer is ignored.
- R9: The count register (address 4) returns the number of stored symbols. A read of the data register (address 5) returns the oldest word and removes it. A data read on an empty FIFO returns 0 and changes nothing.
- R10: A symbol finished while the FIFO is full is discarded and sets the overflow raw flag. The stored words and the count stay as they were.
- R11: The receive raw flag is set while the count exceeds configuration bits 13:8. Writing 1 to bit 16, 17 or 18 of the clear register (address 8) clears the receive, timeout or overflow raw flag, respectively. Clearing the receive flag has no lasting effect while the count still exceeds the level.
- R12: The status register (address 7) shows the raw flags for receive, timeout and overflow in bits 8, 9 and 10. It shows the same flags gated by the mask in bits 24, 25 and 26. Mask register (address 6) bits 0, 1 and 2 suppress the corresponding cause when set. `irq` is the OR of the gated flags.
- R13: Turning the block off empties the FIFO, clears the raw flags and stops capture. Capture then needs a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_in | input | 1 | Demodulated infrared line, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a data read pops a word |
| reg_addr | input | ADDR_W | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as `reg_rd` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a four-word FIFO, a duration unit of one base tick, a three-clock glitch filter, a four-cycle settle time and the extra enable bit required. The small FIFO makes overflow and the discard rule reachable with six symbols. The one-tick unit, combined with a programmed prescaler of 1 or 0, lets a single test drive a pulse count into 0xFFFF saturation. Pulse and space widths of 2n+1 clocks at a prescaler of 1 give an exact expected count of n, whatever the phase of the tick.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

    localparam int DUR_W  = 16;
    localparam int WORD_W = 32;

    // register word addresses
    localparam int A_CTRL  = 0;
    localparam int A_CFG   = 1;
    localparam int A_BUSY  = 2;
    localparam int A_START = 3;
    localparam int A_COUNT = 4;
    localparam int A_DATA  = 5;
    localparam int A_MASK  = 6;
    localparam int A_STAT  = 7;
    localparam int A_CLR   = 8;

    // interrupt cause indices
    localparam int IRQ_RCV = 0;
    localparam int IRQ_TMO = 1;
    localparam int IRQ_OVF = 2;

    // field layout follows the bit positions software programs
    typedef struct packed {
        logic [15:0] max_width;
        logic [1:0]  fmt;
        logic [5:0]  level;
        logic        raw;
        logic [6:0]  presc;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{max_width: 16'h3E80, fmt: 2'd0,
                                   level: 6'd0, raw: 1'b1, presc: 7'd0};

    typedef struct packed {
        logic [DUR_W-1:0] space;
        logic [DUR_W-1:0] pulse;
    } sym_t;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_PULSE = 2'd1,
        MS_SPACE = 2'd2
    } meas_st_t;

endpackage

// File: rtl/ir_rx_filter.sv
module ir_rx_filter #(
    parameter int FILTER_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_in,
    output logic level
);
    localparam int CW = $clog2(FILTER_LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          filt;
        logic [CW-1:0] cnt;
    } st_t;

    st_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], ir_in};
        if (q.sync[1] == q.filt) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(FILTER_LEN - 1)) begin
            d.filt = q.sync[1];
            d.cnt  = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sync: 2'b11, filt: 1'b1, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign level = q.filt;

endmodule

// File: rtl/ir_rx_tick.sv
module ir_rx_tick #(
    parameter int UNIT_TICKS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [6:0] presc,
    output logic       unit_tick
);
    localparam int UW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;

    typedef struct packed {
        logic [6:0]    pre;
        logic [UW-1:0] unit;
    } st_t;

    st_t  q, d;
    logic us_tick;

    assign us_tick = (q.pre >= presc);

    always_comb begin
        d = q;
        if (clr) begin
            d.pre  = '0;
            d.unit = '0;
        end else if (us_tick) begin
            d.pre  = '0;
            d.unit = (q.unit == UW'(UNIT_TICKS - 1)) ? '0 : q.unit + 1'b1;
        end else begin
            d.pre = q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    generate
        if (UNIT_TICKS > 1) begin : g_div
            assign unit_tick = us_tick && (q.unit == UW'(UNIT_TICKS - 1));
        end else begin : g_nodiv
            assign unit_tick = us_tick;
        end
    endgenerate

endmodule

// File: rtl/ir_rx_measure.sv
module ir_rx_measure
    import ir_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              level,
    input  logic              pol_high,
    input  logic              unit_tick,
    input  logic [DUR_W-1:0]  max_width,
    output logic              edge_seen,
    output logic              push,
    output logic [WORD_W-1:0] push_word,
    output logic              frame_end
);
    typedef struct packed {
        meas_st_t         st;
        logic             prev;
        logic [DUR_W-1:0] pulse;
        logic [DUR_W-1:0] space;
    } st_t;

    st_t  q, d;
    logic active;
    sym_t word;

    function automatic logic [DUR_W-1:0] sat_inc(input logic [DUR_W-1:0] v);
        return (v == '1) ? v : v + 1'b1;
    endfunction

    function automatic logic limit_hit(input logic [DUR_W-1:0] p,
                                       input logic [DUR_W-1:0] s,
                                       input logic [DUR_W-1:0] lim);
        logic [DUR_W:0] sum;
        sum = {1'b0, p} + {1'b0, s};
        return (lim != '0) && (sum >= {1'b0, lim});
    endfunction

    assign active    = pol_high ? level : ~level;
    assign edge_seen = (active != q.prev);

    always_comb begin
        d          = q;
        d.prev     = active;
        push       = 1'b0;
        frame_end  = 1'b0;
        word.pulse = q.pulse;
        word.space = q.space;
        if (!run) begin
            d.st    = MS_IDLE;
            d.pulse = '0;
            d.space = '0;
        end else begin
            case (q.st)
                MS_IDLE: begin
                    if (active && !q.prev) begin
                        d.st    = MS_PULSE;
                        d.pulse = '0;
                        d.space = '0;
                    end
                end
                MS_PULSE: begin
                    if (edge_seen) begin
                        d.st = MS_SPACE;
                    end else if (unit_tick) begin
                        d.pulse = sat_inc(q.pulse);
                        if (limit_hit(d.pulse, q.space, max_width)) begin
                            push       = 1'b1;
                            frame_end  = 1'b1;
                            word.pulse = d.pulse;
                            d.st       = MS_IDLE;
                        end
                    end
                end
                MS_SPACE: begin
                    if (edge_seen) begin
                        push    = 1'b1;
                        d.st    = MS_PULSE;
                        d.pulse = '0;
                        d.space = '0;
                    end else if (unit_tick) begin
                        d.space = sat_inc(q.space);
                        if (limit_hit(q.pulse, d.space, max_width)) begin
                            push       = 1'b1;
                            frame_end  = 1'b1;
                            word.space = d.space;
                            d.st       = MS_IDLE;
                        end
                    end
                end
                default: d.st = MS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: MS_IDLE, prev: 1'b0, pulse: '0, space: '0};
        end else begin
            q <= d;
        end
    end

    assign push_word = word;

endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [WIDTH-1:0]             wdata,
    input  logic                         pop,
    output logic [WIDTH-1:0]             rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } st_t;

    st_t        q, d;
    logic       wr_ok, rd_ok;
    logic [WIDTH-1:0] mem [DEPTH];

    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign wr_ok = push && !full && !flush;
    assign rd_ok = pop && !empty && !flush;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (wr_ok) d.wp = nxt(q.wp);
            if (rd_ok) d.rp = nxt(q.rp);
            case ({wr_ok, rd_ok})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[q.wp] <= wdata;
    end

    assign rdata = empty ? '0 : mem[q.rp];
    assign count = q.cnt;

endmodule

// File: rtl/ir_rx_top.sv
module ir_rx_top
    import ir_rx_pkg::*;
#(
    parameter int FIFO_DEPTH    = 64,
    parameter int UNIT_TICKS    = 10,
    parameter int FILTER_LEN    = 4,
    parameter int SETTLE_CYCLES = 8,
    parameter bit NEED_EXTRA_EN = 1'b0,
    parameter int ADDR_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);
    localparam int SW = $clog2(SETTLE_CYCLES + 1);

    typedef struct packed {
        logic          on;
        logic [1:0]    ctrl;
        logic [SW-1:0] settle;
        logic          running;
        cfg_t          cfg;
        logic [2:0]    mask;
        logic [2:0]    raw;
    } st_t;

    st_t q, d;

    logic              filt_level;
    logic              unit_tick;
    logic              edge_seen;
    logic              push;
    logic [WORD_W-1:0] push_word;
    logic              frame_end;
    logic              pop;
    logic [WORD_W-1:0] head;
    logic [CW-1:0]     fifo_cnt;
    logic              full;
    logic              empty;
    logic              busy;
    logic [2:0]        gated;
    logic              flush;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
        return a == ADDR_W'(target);
    endfunction

    ir_rx_filter #(.FILTER_LEN(FILTER_LEN)) filt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ir_in (ir_in),
        .level (filt_level)
    );

    ir_rx_tick #(.UNIT_TICKS(UNIT_TICKS)) tick_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (edge_seen),
        .presc     (q.cfg.presc),
        .unit_tick (unit_tick)
    );

    ir_rx_measure meas_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (q.running),
        .level     (filt_level),
        .pol_high  (q.cfg.fmt == 2'd1),
        .unit_tick (unit_tick),
        .max_width (q.cfg.max_width),
        .edge_seen (edge_seen),
        .push      (push),
        .push_word (push_word),
        .frame_end (frame_end)
    );

    ir_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push),
        .wdata (push_word),
        .pop   (pop),
        .rdata (head),
        .count (fifo_cnt),
        .full  (full),
        .empty (empty)
    );

    assign busy  = !q.on || (q.settle != '0);
    assign flush = !q.on;
    assign pop   = reg_rd && hit(reg_addr, A_DATA) && !empty;
    assign gated = q.raw & ~q.mask;
    assign irq   = |gated;

    always_comb begin
        d = q;

        // power state and settle window
        if (reg_wr && hit(reg_addr, A_CTRL)) begin
            d.ctrl = {reg_wdata[8], reg_wdata[0]};
            d.on   = reg_wdata[0] && (reg_wdata[8] || !NEED_EXTRA_EN);
        end
        if (!q.on) begin
            d.settle = SW'(SETTLE_CYCLES);
        end else if (q.settle != '0) begin
            d.settle = q.settle - 1'b1;
        end

        // configuration and start
        if (reg_wr && hit(reg_addr, A_CFG) && !busy) begin
            d.cfg = cfg_t'(reg_wdata);
        end
        if (reg_wr && hit(reg_addr, A_START) && !busy && q.cfg.raw) begin
            d.running = 1'b1;
        end
        if (reg_wr && hit(reg_addr, A_MASK)) begin
            d.mask = reg_wdata[2:0];
        end

        // sticky raw causes with write-one clear
        d.raw[IRQ_RCV] = (q.raw[IRQ_RCV] &&
                          !(reg_wr && hit(reg_addr, A_CLR) && reg_wdata[16]))
                         || (int'(fifo_cnt) > int'(q.cfg.level));
        d.raw[IRQ_TMO] = (q.raw[IRQ_TMO] &&
                          !(reg_wr && hit(reg_addr, A_CLR) && reg_wdata[17]))
                         || frame_end;
        d.raw[IRQ_OVF] = (q.raw[IRQ_OVF] &&
                          !(reg_wr && hit(reg_addr, A_CLR) && reg_wdata[18]))
                         || (push && full);

        if (!q.on) begin
            d.running = 1'b0;
            d.raw     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{on: 1'b0, ctrl: 2'b00, settle: SW'(SETTLE_CYCLES),
                   running: 1'b0, cfg: CFG_RESET, mask: 3'b111, raw: 3'b000};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (hit(reg_addr, A_CTRL))       reg_rdata = {23'd0, q.ctrl[1], 7'd0, q.ctrl[0]};
            else if (hit(reg_addr, A_CFG))   reg_rdata = q.cfg;
            else if (hit(reg_addr, A_BUSY))  reg_rdata = {31'd0, busy};
            else if (hit(reg_addr, A_COUNT)) reg_rdata = 32'(fifo_cnt);
            else if (hit(reg_addr, A_DATA))  reg_rdata = head;
            else if (hit(reg_addr, A_MASK))  reg_rdata = {29'd0, q.mask};
            else if (hit(reg_addr, A_STAT))  reg_rdata = {5'd0, gated, 13'd0, q.raw, 8'd0};
        end
    end

endmodule

// File: rtl/ir_rx_chk.sv
module ir_rx_chk #(
    parameter int FIFO_DEPTH = 64
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          on,
    input logic                          busy,
    input logic                          running,
    input logic                          push,
    input logic                          frame_end,
    input logic                          pop,
    input logic                          full,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] cnt,
    input logic [2:0]                    raw,
    input logic [2:0]                    mask,
    input logic                          irq
);
    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= FIFO_DEPTH);

    p_pop_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && on) |=> (cnt == $past(cnt) - 1'b1));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && on) |=> ($stable(cnt) && raw[2]));

    p_busy_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !on |-> busy);

    p_push_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> running);

    p_timeout_stores_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> push);

    p_mask_all_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 3'b111) |-> !irq);

    p_off_clears_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> (raw == 3'b000 || on));

endmodule

bind ir_rx_top ir_rx_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .on        (q.on),
    .busy      (busy),
    .running   (q.running),
    .push      (push),
    .frame_end (frame_end),
    .pop       (pop),
    .full      (full),
    .cnt       (fifo_cnt),
    .raw       (q.raw),
    .mask      (q.mask),
    .irq       (irq)
);

// File: tb/ir_rx_top_tb_top.sv
module ir_rx_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int MAXW       = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_in = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_rx_top #(
        .FIFO_DEPTH(DEPTH), .UNIT_TICKS(1), .FILTER_LEN(3),
        .SETTLE_CYCLES(4), .NEED_EXTRA_EN(1'b1), .ADDR_W(4)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // {fmt_high, pulse units, space units}
    localparam logic [16:0] VEC [6] = '{
        {1'b0, 8'd3,  8'd5},
        {1'b1, 8'd7,  8'd2},
        {1'b0, 8'd1,  8'd1},
        {1'b1, 8'd10, 8'd8},
        {1'b0, 8'd12, 8'd6},
        {1'b0, 8'd2,  8'd16}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 4'(a);
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic hold(input logic lvl, input int n);
        ir_in = lvl;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] mkcfg(input int mw, input int fmt, input int lvl,
                                          input bit raw, input int presc);
        return {16'(mw), 2'(fmt), 6'(lvl), raw, 7'(presc)};
    endfunction

    task automatic bring_up(input logic idle, input logic [31:0] cfg);
        @(negedge clk);
        ir_in = idle;
        wr(0, 32'h0);
        wr(0, 32'h101);
        repeat (8) @(negedge clk);
        wr(1, cfg);
        wr(3, 32'h1);
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000 && !done) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected<190000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2, v); check("R1 busy", v, 32'd1);
        rd(4, v); check("R1 count", v, 32'd0);
        rd(7, v); check("R1 status", v, 32'd0);
        rd(1, v); check("R1 cfg", v, 32'h3E80_0080);
        rd(6, v); check("R1 mask", v, 32'd7);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R2 extra enable bit required
        wr(0, 32'h1);
        repeat (10) @(negedge clk);
        rd(2, v); check("R2 busy without extra bit", v, 32'd1);
        wr(0, 32'h101);
        rd(2, v); check("R2 busy during settle", v, 32'd1);
        repeat (10) @(negedge clk);
        rd(2, v); check("R2 ready", v, 32'd0);

        // R3 cfg ignored while busy, start ignored with raw mode off
        wr(0, 32'h0);
        wr(0, 32'h101);
        wr(1, mkcfg(MAXW, 0, 0, 1'b1, 1));
        rd(1, v); check("R3 cfg write while busy", v, 32'h3E80_0080);
        repeat (8) @(negedge clk);
        wr(1, mkcfg(MAXW, 0, 0, 1'b0, 1));
        wr(3, 32'h1);
        hold(1'b0, 7); hold(1'b1, 7); hold(1'b0, 7); hold(1'b1, 80);
        rd(4, v); check("R3 start ignored without raw mode", v, 32'd0);

        // R4 R5 R6 table of symbol shapes and polarities
        for (int i = 0; i < 6; i++) begin
            logic fmt_h;
            int p, s;
            logic idle;
            fmt_h = VEC[i][16];
            p = int'(VEC[i][15:8]);
            s = int'(VEC[i][7:0]);
            idle = ~fmt_h;
            bring_up(idle, mkcfg(MAXW, fmt_h ? 1 : 0, 3, 1'b1, 1));
            hold(~idle, 2*p + 1);
            hold(idle, 2*s + 1);
            hold(~idle, 3);
            hold(idle, 80);
            rd(4, v); check($sformatf("R5 vec%0d count", i), v, 32'd2);
            rd(5, v); check($sformatf("R4 R5 vec%0d word", i), v, {16'(s), 16'(p)});
            rd(5, v); check($sformatf("R6 vec%0d frame end word", i), v, {16'(MAXW - 1), 16'd1});
            rd(7, v); check($sformatf("R6 vec%0d timeout raw", i), v & 32'h200, 32'h200);
        end

        // R6 over-long pulse closes frame; release alone starts nothing
        bring_up(1'b1, mkcfg(MAXW, 0, 3, 1'b1, 1));
        hold(1'b0, 51);
        hold(1'b1, 60);
        rd(4, v); check("R6 long pulse one word", v, 32'd1);
        rd(5, v); check("R6 long pulse word", v, {16'd0, 16'(MAXW)});
        hold(1'b0, 5); hold(1'b1, 80);
        rd(4, v); check("R6 fresh edge starts symbol", v, 32'd1);
        rd(5, v); check("R6 fresh symbol word", v, {16'(MAXW - 2), 16'd2});

        // R8 glitch in the space is filtered
        bring_up(1'b1, mkcfg(MAXW, 0, 3, 1'b1, 1));
        hold(1'b0, 7); hold(1'b1, 10); hold(1'b0, 2); hold(1'b1, 80);
        rd(4, v); check("R8 glitch count", v, 32'd1);
        rd(5, v); check("R8 glitch word", v, {16'(MAXW - 3), 16'd3});

        // R9 empty read
        rd(5, v); check("R9 empty data read", v, 32'd0);
        rd(4, v); check("R9 empty count", v, 32'd0);

        // R10 R11 R12 overflow, level, mask
        bring_up(1'b1, mkcfg(MAXW, 0, 1, 1'b1, 1));
        for (int k = 1; k <= 5; k++) begin
            hold(1'b0, 2*k + 1);
            hold(1'b1, 5);
        end
        hold(1'b0, 3);
        hold(1'b1, 80);
        rd(4, v); check("R10 count kept at depth", v, 32'(DEPTH));
        rd(7, v); check("R12 status masked", v, 32'h0000_0700);
        check("R12 irq masked", {31'd0, irq}, 32'd0);
        wr(6, 32'h0);
        rd(7, v); check("R12 status unmasked", v, 32'h0700_0700);
        check("R12 irq unmasked", {31'd0, irq}, 32'd1);
        wr(6, 32'h3);
        rd(7, v); check("R12 overflow only", v, 32'h0400_0700);
        wr(8, 32'h0001_0000);
        rd(7, v); check("R11 rcv clear while above level", v & 32'h100, 32'h100);
        for (int k = 1; k <= DEPTH; k++) begin
            rd(5, v); check($sformatf("R10 kept word %0d", k), v, {16'd2, 16'(k)});
        end
        wr(8, 32'h0007_0000);
        rd(7, v); check("R11 clear all", v, 32'd0);
        check("R11 irq after clear", {31'd0, irq}, 32'd0);

        // R7 saturation, prescaler 0, timeout disabled
        bring_up(1'b1, mkcfg(0, 0, 3, 1'b1, 0));
        hold(1'b0, 66000);
        hold(1'b1, 7);
        hold(1'b0, 3);
        hold(1'b1, 20);
        rd(4, v); check("R7 count", v, 32'd1);
        rd(5, v); check("R7 saturated pulse", v & 32'hFFFF, 32'hFFFF);
        hold(1'b0, 5);
        hold(1'b1, 20);
        rd(4, v); check("R13 word before disable", v, 32'd1);

        // R13 disable flushes and stops capture
        wr(0, 32'h0);
        rd(4, v); check("R13 count after disable", v, 32'd0);
        rd(2, v); check("R13 busy after disable", v, 32'd1);
        wr(0, 32'h101);
        repeat (8) @(negedge clk);
        hold(1'b0, 5); hold(1'b1, 5); hold(1'b0, 5); hold(1'b1, 20);
        rd(4, v); check("R13 no capture without start", v, 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule